// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block drives the two control strobes of a multiplexed 8-bit external memory bus. The first is the address latch pulse (ALE). The second is the active-low program store enable (PSEN_n). Both are timed from the oscillator clock inside a machine cycle of STATES × PHASES oscillator periods, which is six states of two phases by default.

At reset the block captures the external-access pin. At the end of every machine cycle it then decides where the next cycle's fetch goes: to internal program memory or out to the bus. The decision uses the latched pin and the program counter, compared against the internal memory size. A request for an external data move can also claim the following machine cycle. In that cycle the address strobe fires only once and the fetch strobes are skipped.

A quiet-ALE input keeps the address latch still while fetches stay on chip. Idle and power-down inputs force resting levels on both strobes. The CPU, the port drivers and the data read and write strobes sit outside this block.

Top module: `bus_strobe_seq`

## Requirements
- R1: Slots are counted within the machine cycle as slot = 2·state + phase, giving 0..11. After reset is released, the k-th rising clock edge presents on the registered outputs the strobes for slot (k−1) mod 12. In normal toggling, ALE is high for exactly one period at slots 1 and 7.
- R2: In a cycle whose fetch goes to the bus, psen_n_o is low in slots 0–3 and 6–9 and high in slots 4, 5, 10 and 11. ALE toggles normally in such a cycle.
- R3: psen_n_o is high for the whole cycle whenever that cycle holds no external fetch. This covers internal fetches, data-move cycles, idle and power-down.
- R4: ext_access_latched_o copies ext_access_i while rst_i is high. Changes on ext_access_i after reset have no effect on that output or on the strobes.
- R5: With the latched pin high, a cycle fetches internally when pc_i is below INT_MEM_SIZE and externally when pc_i is at or above it. pc_i is sampled at the slot-11 edge of the previous cycle, or during reset for the first cycle.
- R6: With the latched pin low, every fetch cycle is external. In those cycles ALE toggles normally whatever quiet_ale_i says.
- R7: When quiet_ale_i is high and the cycle fetches internally, ale_o stays low for the whole cycle.
- R8: movx_req_i is sampled at the slot-11 edge. If it is high, the next cycle is a data-move cycle: ALE pulses only at slot 7, psen_n_o stays high, and quiet_ale_i has no effect.
- R9: While idle_i is high, psen_n_o is high. ale_o is then held high if quiet_ale_i is high, and otherwise follows the slot 1/7 pattern.
- R10: The edge that samples pwr_down_i high drives ale_o low and psen_n_o high. From then until the next reset no strobe moves, even after pwr_down_i falls.
- R11: While rst_i is high, ale_o is low and psen_n_o is high, and the slot counter returns to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock, one period per phase |
| rst_i | input | 1 | Synchronous active-high reset |
| ext_access_i | input | 1 | External-access pin, captured during reset |
| quiet_ale_i | input | 1 | Software bit that silences ALE for internal fetches |
| idle_i | input | 1 | Idle mode flag |
| pwr_down_i | input | 1 | Power-down request, sticky until reset |
| pc_i | input | PC_W | Program counter of the next fetch |
| movx_req_i | input | 1 | External data move request for the next cycle |
| ale_o | output | 1 | Address latch enable |
| psen_n_o | output | 1 | Program store enable, active low |
| ext_access_latched_o | output | 1 | External-access level captured at reset |

## Verification
The bench builds the block with PC_W = 8 and INT_MEM_SIZE = 128 and keeps the default six-state, two-phase cycle. With a small counter, the boundary between internal and external fetches sits at pc values 127 and 128, and 255 wraps the top. The bench places addresses on both sides of that boundary, and the short cycle keeps every slot-by-slot strobe comparison cheap.

// File: rtl/bus_strobe_pkg.sv
package bus_strobe_pkg;

  typedef enum logic [2:0] {
    SM_INT  = 3'd0,
    SM_EXT  = 3'd1,
    SM_MOVX = 3'd2,
    SM_IDLE = 3'd3,
    SM_HALT = 3'd4
  } strobe_mode_e;

endpackage

// File: rtl/bus_strobe_timebase.sv
module bus_strobe_timebase #(
  parameter int STATES = 6,
  parameter int PHASES = 2,
  localparam int ST_W = (STATES > 1) ? $clog2(STATES) : 1,
  localparam int PH_W = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            pwr_down_i,
  output logic [ST_W-1:0] state_o,
  output logic [PH_W-1:0] phase_o,
  output logic            cyc_end_o,
  output logic            halt_o
);

  localparam logic [ST_W-1:0] ST_LAST = ST_W'(STATES - 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);

  logic            halted_q;
  logic [ST_W-1:0] state_q;
  logic [PH_W-1:0] phase_q;
  logic            step_state;

  assign halt_o = halted_q | pwr_down_i;

  always_ff @(posedge clk_i) begin
    if (rst_i)           halted_q <= 1'b0;
    else if (pwr_down_i) halted_q <= 1'b1;
  end

  generate
    if (PHASES > 1) begin : g_phase
      always_ff @(posedge clk_i) begin
        if (rst_i)        phase_q <= '0;
        else if (!halt_o) phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
      end
      assign step_state = (phase_q == PH_LAST);
    end else begin : g_single_phase
      assign phase_q    = '0;
      assign step_state = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= '0;
    end else if (!halt_o && step_state) begin
      state_q <= (state_q == ST_LAST) ? '0 : state_q + 1'b1;
    end
  end

  assign state_o   = state_q;
  assign phase_o   = phase_q;
  assign cyc_end_o = (state_q == ST_LAST) && (phase_q == PH_LAST) && !halt_o;

  // R1: the slot after the last one of a machine cycle is slot 0
  p_wrap_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    cyc_end_o |=> (state_q == '0) && (phase_q == '0));

endmodule

// File: rtl/bus_strobe_fetch.sv
module bus_strobe_fetch #(
  parameter int PC_W         = 16,
  parameter int INT_MEM_SIZE = 32768
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            ext_access_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic            movx_req_i,
  input  logic            cyc_end_i,
  output logic            ea_lat_o,
  output logic            cyc_ext_o,
  output logic            cyc_movx_o
);

  localparam logic [PC_W:0] LIMIT = (PC_W + 1)'(INT_MEM_SIZE);

  logic ea_lat_q, ext_q, movx_q;
  logic pc_beyond;

  assign pc_beyond = ({1'b0, pc_i} >= LIMIT);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ea_lat_q <= ext_access_i;
      ext_q    <= !ext_access_i || pc_beyond;
      movx_q   <= 1'b0;
    end else if (cyc_end_i) begin
      ext_q    <= !ea_lat_q || pc_beyond;
      movx_q   <= movx_req_i;
    end
  end

  assign ea_lat_o   = ea_lat_q;
  assign cyc_ext_o  = ext_q;
  assign cyc_movx_o = movx_q;

  // R4: the captured pin level never moves outside reset
  p_ea_hold_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) |-> $stable(ea_lat_q));

  // R8: the data-move flag only changes on a machine-cycle boundary
  p_movx_boundary_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && !$past(cyc_end_i)) |-> $stable(movx_q));

  // R6: with the pin latched low every cycle after a boundary is external
  p_ext_when_low_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (!ea_lat_q && $past(cyc_end_i) && !$past(rst_i)) |-> ext_q);

endmodule

// File: rtl/bus_strobe_drive.sv
module bus_strobe_drive
  import bus_strobe_pkg::*;
#(
  parameter int STATES = 6,
  parameter int PHASES = 2,
  localparam int ST_W = (STATES > 1) ? $clog2(STATES) : 1,
  localparam int PH_W = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic [ST_W-1:0] state_i,
  input  logic [PH_W-1:0] phase_i,
  input  logic            cyc_ext_i,
  input  logic            cyc_movx_i,
  input  logic            quiet_ale_i,
  input  logic            idle_i,
  input  logic            halt_i,
  output logic            ale_o,
  output logic            psen_n_o
);

  localparam logic [ST_W-1:0] S_A0  = ST_W'(0);
  localparam logic [ST_W-1:0] S_A0B = ST_W'(1);
  localparam logic [ST_W-1:0] S_A1  = ST_W'(STATES / 2);
  localparam logic [ST_W-1:0] S_A1B = ST_W'(STATES / 2 + 1);
  localparam logic [PH_W-1:0] P_LAST = PH_W'(PHASES - 1);

  strobe_mode_e mode;
  logic ale_slot, movx_slot, fetch_win;
  logic ale_d, psen_n_d;
  logic ale_q, psen_n_q, idle_seen_q;

  assign ale_slot  = (phase_i == P_LAST) && ((state_i == S_A0) || (state_i == S_A1));
  assign movx_slot = (phase_i == P_LAST) && (state_i == S_A1);
  assign fetch_win = (state_i == S_A0) || (state_i == S_A0B) ||
                     (state_i == S_A1) || (state_i == S_A1B);

  always_comb begin
    if (halt_i)          mode = SM_HALT;
    else if (idle_i)     mode = SM_IDLE;
    else if (cyc_movx_i) mode = SM_MOVX;
    else if (cyc_ext_i)  mode = SM_EXT;
    else                 mode = SM_INT;
  end

  always_comb begin
    ale_d    = 1'b0;
    psen_n_d = 1'b1;
    unique case (mode)
      SM_HALT: begin ale_d = 1'b0;                    psen_n_d = 1'b1;       end
      SM_IDLE: begin ale_d = quiet_ale_i | ale_slot;  psen_n_d = 1'b1;       end
      SM_MOVX: begin ale_d = movx_slot;               psen_n_d = 1'b1;       end
      SM_EXT:  begin ale_d = ale_slot;                psen_n_d = !fetch_win; end
      SM_INT:  begin ale_d = ale_slot & !quiet_ale_i; psen_n_d = 1'b1;       end
      default: begin ale_d = 1'b0;                    psen_n_d = 1'b1;       end
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ale_q       <= 1'b0;
      psen_n_q    <= 1'b1;
      idle_seen_q <= 1'b0;
    end else begin
      ale_q       <= ale_d;
      psen_n_q    <= psen_n_d;
      idle_seen_q <= idle_i;
    end
  end

  assign ale_o    = ale_q;
  assign psen_n_o = psen_n_q;

  // R1: two ALE-high periods in a row only come from idle with the quiet bit
  p_ale_single_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    (ale_q && $past(ale_q)) |-> $past(idle_i));

  // R2: a fetch strobe starts only at the first phase of a fetch window
  p_psen_start_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    ($fell(psen_n_q) && !$past(idle_seen_q)) |->
      ($past(phase_i) == '0) && (($past(state_i) == S_A0) || ($past(state_i) == S_A1)));

  // R3: no fetch strobe in a cycle that is not an external fetch
  p_psen_int_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(cyc_ext_i) |-> psen_n_q);

  // R8: data-move cycles carry no fetch strobe
  p_movx_psen_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(cyc_movx_i) |-> psen_n_q);

  // R10: power-down leaves both strobes at rest
  p_halt_quiet_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(halt_i) |-> (!ale_q && psen_n_q));

endmodule

// File: rtl/bus_strobe_seq.sv
module bus_strobe_seq #(
  parameter int STATES       = 6,
  parameter int PHASES       = 2,
  parameter int PC_W         = 16,
  parameter int INT_MEM_SIZE = 32768
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            ext_access_i,
  input  logic            quiet_ale_i,
  input  logic            idle_i,
  input  logic            pwr_down_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic            movx_req_i,
  output logic            ale_o,
  output logic            psen_n_o,
  output logic            ext_access_latched_o
);

  localparam int ST_W = (STATES > 1) ? $clog2(STATES) : 1;
  localparam int PH_W = (PHASES > 1) ? $clog2(PHASES) : 1;

  logic [ST_W-1:0] state;
  logic [PH_W-1:0] phase;
  logic cyc_end, halt, cyc_ext, cyc_movx;

  bus_strobe_timebase #(.STATES(STATES), .PHASES(PHASES)) u_time (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .pwr_down_i (pwr_down_i),
    .state_o    (state),
    .phase_o    (phase),
    .cyc_end_o  (cyc_end),
    .halt_o     (halt)
  );

  bus_strobe_fetch #(.PC_W(PC_W), .INT_MEM_SIZE(INT_MEM_SIZE)) u_fetch (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .ext_access_i (ext_access_i),
    .pc_i         (pc_i),
    .movx_req_i   (movx_req_i),
    .cyc_end_i    (cyc_end),
    .ea_lat_o     (ext_access_latched_o),
    .cyc_ext_o    (cyc_ext),
    .cyc_movx_o   (cyc_movx)
  );

  bus_strobe_drive #(.STATES(STATES), .PHASES(PHASES)) u_drive (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .state_i     (state),
    .phase_i     (phase),
    .cyc_ext_i   (cyc_ext),
    .cyc_movx_i  (cyc_movx),
    .quiet_ale_i (quiet_ale_i),
    .idle_i      (idle_i),
    .halt_i      (halt),
    .ale_o       (ale_o),
    .psen_n_o    (psen_n_o)
  );

  // R11: strobes are at rest one edge after reset is seen
  p_reset_rest_r11: assert property (@(posedge clk_i)
    $past(rst_i) |-> (!ale_o && psen_n_o));

endmodule

// File: tb/sim_bus_strobe_seq.sv
`timescale 1ns/1ps
module sim_bus_strobe_seq;
  localparam int PCW = 8;
  localparam int LIM = 128;
  localparam int NV  = 12;

  // {pc[7:0], movx, quiet, idle}
  localparam logic [10:0] VEC [NV] = '{
    {8'h10, 3'b000},  // internal, ALE toggles          R1 R3
    {8'h10, 3'b010},  // internal, quiet ALE            R7
    {8'h80, 3'b010},  // exactly at limit -> external   R5 R2
    {8'h7F, 3'b000},  // just below limit -> internal   R5
    {8'h7F, 3'b100},  // data move                      R8
    {8'h7F, 3'b110},  // data move with quiet bit       R8
    {8'hFF, 3'b000},  // top address -> external        R5
    {8'h20, 3'b011},  // idle with quiet -> ALE high    R9
    {8'h20, 3'b001},  // idle without quiet             R9
    {8'h90, 3'b000},  // external                       R2
    {8'h00, 3'b010},  // internal quiet                 R7
    {8'h00, 3'b000}   // internal                       R1
  };

  logic clk = 1'b0;
  logic rst, ea, quiet, idl, pd, movx;
  logic [PCW-1:0] pc;
  logic ale, psen_n, eal;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bus_strobe_seq #(.PC_W(PCW), .INT_MEM_SIZE(LIM)) u0 (
    .clk_i(clk), .rst_i(rst), .ext_access_i(ea), .quiet_ale_i(quiet),
    .idle_i(idl), .pwr_down_i(pd), .pc_i(pc), .movx_req_i(movx),
    .ale_o(ale), .psen_n_o(psen_n), .ext_access_latched_o(eal)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic void expect_at(input int s, input bit ext, input bit mv,
                                    input bit q, input bit id,
                                    output bit a, output bit p);
    bit als;
    bit win;
    als = (s == 1) || (s == 7);
    win = (s <= 3) || (s >= 6 && s <= 9);
    if (id)       begin a = q | als;  p = 1'b1; end
    else if (mv)  begin a = (s == 7); p = 1'b1; end
    else if (ext) begin a = als;      p = !win; end
    else          begin a = als & !q; p = 1'b1; end
  endfunction

  // called at a negedge just before slot 0 of a machine cycle
  task automatic run_cycle(input bit ext, input bit mv, input bit q, input bit id, input string tag);
    bit a, p;
    for (int s = 0; s < 12; s++) begin
      @(negedge clk);
      expect_at(s, ext, mv, q, id, a, p);
      chk(tag, $sformatf("ale slot %0d", s), ale, a);
      chk(tag, $sformatf("psen_n slot %0d", s), psen_n, p);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; ea = 1'b1; quiet = 1'b0; idl = 1'b0; pd = 1'b0;
    pc = VEC[0][10:3]; movx = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11", "ale in reset", ale, 1'b0);
    chk("R11", "psen_n in reset", psen_n, 1'b1);
    chk("R4", "latched pin in reset", eal, 1'b1);
    rst = 1'b0;

    // table walk
    for (int i = 0; i < NV; i++) begin
      bit ext;
      string tag;
      quiet = VEC[i][1];
      idl   = VEC[i][0];
      if (i + 1 < NV) begin pc = VEC[i+1][10:3]; movx = VEC[i+1][2]; end
      else            begin pc = 8'h10;          movx = 1'b0;        end
      ext = (int'(VEC[i][10:3]) >= LIM);
      if (VEC[i][0])      tag = "R9";
      else if (VEC[i][2]) tag = "R8";
      else if (ext)       tag = "R2/R5";
      else if (VEC[i][1]) tag = "R7";
      else                tag = "R1/R3";
      run_cycle(ext, VEC[i][2], VEC[i][1], VEC[i][0], tag);
    end

    // R4: pin change after reset is ignored
    ea = 1'b0; quiet = 1'b1; idl = 1'b0;
    run_cycle(1'b0, 1'b0, 1'b1, 1'b0, "R4");
    chk("R4", "latched pin after change", eal, 1'b1);

    // R11 / R6: reset mid-run with the pin low
    rst = 1'b1; pc = 8'h10; quiet = 1'b1;
    @(negedge clk);
    chk("R11", "ale after reset edge", ale, 1'b0);
    chk("R11", "psen_n after reset edge", psen_n, 1'b1);
    chk("R4", "latched pin low", eal, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    run_cycle(1'b1, 1'b0, 1'b1, 1'b0, "R6");
    run_cycle(1'b1, 1'b0, 1'b1, 1'b0, "R6");

    // R10: power-down with quiet bit, then release of the request
    pd = 1'b1;
    @(negedge clk);
    chk("R10", "ale in power-down", ale, 1'b0);
    chk("R10", "psen_n in power-down", psen_n, 1'b1);
    pd = 1'b0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      chk("R10", "ale stays quiet", ale, 1'b0);
      chk("R10", "psen_n stays high", psen_n, 1'b1);
    end

    // R10: power-down without quiet bit, in the middle of a fetch window
    rst = 1'b1; ea = 1'b1; pc = 8'h90; quiet = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    run_cycle(1'b1, 1'b0, 1'b0, 1'b0, "R2");
    @(negedge clk);
    chk("R2", "psen_n slot 0", psen_n, 1'b0);
    pd = 1'b1;
    @(negedge clk);
    chk("R10", "ale forced low", ale, 1'b0);
    chk("R10", "psen_n forced high", psen_n, 1'b1);
    pd = 1'b0;
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      chk("R10", "ale held", ale, 1'b0);
      chk("R10", "psen_n held", psen_n, 1'b1);
    end

    // R11: reset leaves power-down and restarts at slot 0
    rst = 1'b1; pc = 8'h10;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    run_cycle(1'b0, 1'b0, 1'b0, 1'b0, "R11");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule